// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a two-bank single-data-rate SDRAM and owns the command pins while the memory is brought up and whenever it needs refreshing. After reset it keeps the command bus at NOP with the clock enable low for a programmable pause. It then raises the clock enable for one quiet cycle and closes every bank with a precharge-all. Next it issues a fixed number of auto-refresh commands spaced by the row-cycle time, and finally writes the mode register with an operating code taken from an input port.

Once the mode write has settled, the sequencer hands the bus to a user port by raising `seq_ready`. A free-running interval counter then raises an internal refresh request at a fixed period. While a request is pending, `seq_ready` is low. The user port finishes what it is doing and signals that it has gone quiet on `user_idle`. The sequencer then issues a precharge-all followed by one auto-refresh, waits out the row-cycle time, and returns the bus. The handshake has plain control levels and carries no data: the user port may drive the memory only while `seq_ready` is high, and it must keep `user_idle` high until `seq_ready` comes back. All delays are set in clock cycles by parameters, and each gap parameter must be at least 2.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: While reset is asserted, CKE is low, the command is NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), the address and bank outputs are zero and `seq_ready` is low.
- R2: After reset release, the command stays NOP with CKE low for exactly WAIT_CYC cycles. One more NOP cycle follows with CKE high, and CKE stays high from then on.
- R3: Precharge-all is encoded as 4'b0010 with address bit A10 (the top address bit) high. It is issued in the cycle right after the CKE-high NOP cycle.
- R4: Auto-refresh is encoded as 4'b0001. During power-up, INIT_REFS of them are issued. The first comes TRP_CYC cycles after the precharge-all and each later one comes TRC_CYC cycles after the one before.
- R5: Mode register set is encoded as 4'b0000 and is issued TRC_CYC cycles after the last power-up refresh. During it, A[MODE_W-1:0] carries `mode_code`, while the address bits above that field and the bank bit are low.
- R6: `seq_ready` first rises TMRD_CYC cycles after the mode register set, with only NOP in between.
- R7: A refresh request becomes pending every REF_INTERVAL cycles, counted from the first ready cycle whether or not earlier requests were serviced late. `seq_ready` is low in every cycle in which a request is pending.
- R8: While a request is pending and `user_idle` is low, the sequencer issues no command.
- R9: In the cycle after a request is pending with `user_idle` high, a precharge-all is issued. One auto-refresh follows TRP_CYC cycles later, and `seq_ready` returns TRC_CYC cycles after that refresh.
- R10: In every cycle without a command the pins show NOP with a zero address. No command is ever issued while `seq_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_code | input | MODE_W | Operating code written to the mode register; must be stable during power-up |
| user_idle | input | 1 | User port has no operation in flight |
| seq_ready | output | 1 | Bus is available to the user port |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus A0 upward |
| sd_bank | output | 1 | Bank select bit |

## Verification
The command pins are decoded from the state register, so a command appears in the same cycle its state is entered. Every power-up command is therefore due at an absolute cycle count after reset release that follows directly from WAIT_CYC, TRP_CYC, TRC_CYC and TMRD_CYC. The bench builds these cycle numbers from the parameters and stamps each observed command with the clock count taken at the falling edge, so every comparison is made at an exact cycle. The refresh request is checked at the cycle it becomes pending and one cycle before, the service commands are checked one cycle and one plus TRP_CYC cycles after `user_idle` rises, and `seq_ready` is sampled on both sides of its return edge.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [3:0] {
    ST_PWR,   // power-up pause, CKE low
    ST_CKE,   // one NOP with CKE high
    ST_PALL,  // precharge all banks
    ST_TRP,   // precharge recovery
    ST_REF,   // auto-refresh
    ST_TRC,   // row-cycle recovery
    ST_MRS,   // mode register write
    ST_TMRD,  // mode write recovery
    ST_IDLE   // bus handed to user port
  } seq_state_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP  = sd_cmd_t'(4'b0111);
  localparam sd_cmd_t CMD_PALL = sd_cmd_t'(4'b0010);
  localparam sd_cmd_t CMD_REF  = sd_cmd_t'(4'b0001);
  localparam sd_cmd_t CMD_MRS  = sd_cmd_t'(4'b0000);

endpackage

// File: rtl/sdr_seq_wait_timer.sv
module sdr_seq_wait_timer #(
  parameter int TW        = 8,
  parameter int RESET_VAL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= TW'(RESET_VAL);
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdr_seq_refresh_timer.sv
module sdr_seq_refresh_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic take,
  output logic pending
);
  localparam int IW = $clog2(INTERVAL + 1);

  logic [IW-1:0] cnt_q;
  logic          tick;

  assign tick = enable && (cnt_q == IW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else if (enable)  cnt_q <= cnt_q + 1'b1;
  end

  // a new interval elapsing wins over a service grant in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= tick | (pending & ~take);
  end
endmodule

// File: rtl/sdr_seq_cmd_drive.sv
module sdr_seq_cmd_drive
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int MODE_W = 7
) (
  input  seq_state_t        state,
  input  logic [MODE_W-1:0] mode_code,
  output logic              cke,
  output sd_cmd_t           cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              bank
);
  localparam int AP_BIT = ADDR_W - 1;

  logic is_pall, is_mrs;

  assign is_pall = (state == ST_PALL);
  assign is_mrs  = (state == ST_MRS);
  assign cke     = (state != ST_PWR);
  assign bank    = 1'b0;

  always_comb begin
    case (state)
      ST_PALL: cmd = CMD_PALL;
      ST_REF:  cmd = CMD_REF;
      ST_MRS:  cmd = CMD_MRS;
      default: cmd = CMD_NOP;
    endcase
  end

  for (genvar i = 0; i < ADDR_W; i++) begin : g_addr
    if (i < MODE_W) begin : g_mode
      if (i == AP_BIT) begin : g_ap
        assign addr[i] = (is_mrs & mode_code[i]) | is_pall;
      end else begin : g_plain
        assign addr[i] = is_mrs & mode_code[i];
      end
    end else if (i == AP_BIT) begin : g_ap_hi
      assign addr[i] = is_pall;
    end else begin : g_zero
      assign addr[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int MODE_W       = 7,
  parameter int WAIT_CYC     = 10000,
  parameter int TRP_CYC      = 2,
  parameter int TRC_CYC      = 4,
  parameter int TMRD_CYC     = 2,
  parameter int INIT_REFS    = 8,
  parameter int REF_INTERVAL = 780
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_code,
  input  logic              user_idle,
  output logic              seq_ready,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              sd_bank
);
  localparam int G1   = (TRP_CYC > TRC_CYC) ? TRP_CYC : TRC_CYC;
  localparam int G2   = (G1 > TMRD_CYC) ? G1 : TMRD_CYC;
  localparam int MAXG = (G2 > WAIT_CYC) ? G2 : WAIT_CYC;
  localparam int TW   = $clog2(MAXG + 1);
  localparam int RCW  = $clog2(INIT_REFS + 1);

  seq_state_t     st_q, st_d;
  logic           tmr_load, tmr_zero;
  logic [TW-1:0]  tmr_val;
  logic [RCW-1:0] refs_q;
  logic           done_q;
  logic           req_pend, req_take;
  sd_cmd_t        cmd;

  sdr_seq_wait_timer #(.TW(TW), .RESET_VAL(WAIT_CYC - 1)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_zero)
  );

  sdr_seq_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_rtimer (
    .clk(clk), .rst_n(rst_n), .enable(done_q), .take(req_take),
    .pending(req_pend)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    req_take = 1'b0;
    case (st_q)
      ST_PWR:  if (tmr_zero) st_d = ST_CKE;
      ST_CKE:  st_d = ST_PALL;
      ST_PALL: begin
        st_d = ST_TRP; tmr_load = 1'b1; tmr_val = TW'(TRP_CYC - 2);
      end
      ST_TRP:  if (tmr_zero) st_d = ST_REF;
      ST_REF:  begin
        st_d = ST_TRC; tmr_load = 1'b1; tmr_val = TW'(TRC_CYC - 2);
      end
      ST_TRC:  if (tmr_zero) begin
        if (done_q)                        st_d = ST_IDLE;
        else if (refs_q < RCW'(INIT_REFS)) st_d = ST_REF;
        else                               st_d = ST_MRS;
      end
      ST_MRS:  begin
        st_d = ST_TMRD; tmr_load = 1'b1; tmr_val = TW'(TMRD_CYC - 2);
      end
      ST_TMRD: if (tmr_zero) st_d = ST_IDLE;
      ST_IDLE: if (req_pend && user_idle) begin
        st_d = ST_PALL; req_take = 1'b1;
      end
      default: st_d = ST_PWR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PWR;
      refs_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_REF && !done_q) refs_q <= refs_q + 1'b1;
      if (st_q == ST_TMRD && tmr_zero) done_q <= 1'b1;
    end
  end

  sdr_seq_cmd_drive #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_drive (
    .state(st_q), .mode_code(mode_code), .cke(sd_cke), .cmd(cmd),
    .addr(sd_addr), .bank(sd_bank)
  );

  assign sd_cs_n   = cmd.cs_n;
  assign sd_ras_n  = cmd.ras_n;
  assign sd_cas_n  = cmd.cas_n;
  assign sd_we_n   = cmd.we_n;
  assign seq_ready = (st_q == ST_IDLE) && !req_pend;
endmodule

// File: rtl/sdr_seq_checker.sv
module sdr_seq_checker #(
  parameter int ADDR_W = 11,
  parameter int MODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seq_ready,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              sd_bank
);
  logic [3:0] pins;
  logic is_nop, is_pall, is_ref, is_mrs;

  assign pins    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_nop  = (pins == 4'b0111);
  assign is_pall = (pins == 4'b0010);
  assign is_ref  = (pins == 4'b0001);
  assign is_mrs  = (pins == 4'b0000);

  p_cke_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke |=> sd_cke);

  p_cke_before_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |-> $past(sd_cke));

  p_pall_ap_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_pall |-> sd_addr[ADDR_W-1]);

  p_ref_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |=> is_nop);

  p_mrs_upper_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> ((sd_addr >> MODE_W) == '0) && !sd_bank);

  p_pall_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_pall |=> is_nop);

  p_ready_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_ready |-> is_nop);

  p_nop_addr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop |-> (sd_addr == '0));
endmodule

bind sdram_init_refresh_seq sdr_seq_checker #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .seq_ready(seq_ready), .sd_cke(sd_cke),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
  .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_bank(sd_bank)
);

// File: tb/tb_sdram_init_refresh_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_refresh_seq;
  localparam int ADDR_W = 11, MODE_W = 7;
  localparam int WAIT = 20, TRP = 2, TRC = 4, TMRD = 2, NREF = 8, INTV = 100;

  localparam logic [3:0] K_NOP = 4'b0111, K_PALL = 4'b0010,
                         K_REF = 4'b0001, K_MRS = 4'b0000;

  localparam int C_PALL = WAIT + 1;
  localparam int C_REF0 = C_PALL + TRP;
  localparam int C_MRS  = C_REF0 + NREF * TRC;
  localparam int C_RDY  = C_MRS + TMRD;
  localparam int P1     = C_RDY + INTV;

  localparam int NEXP = 10;
  localparam logic [3:0] EXP_CMD [NEXP] = '{K_PALL, K_REF, K_REF, K_REF, K_REF,
                                            K_REF, K_REF, K_REF, K_REF, K_MRS};
  localparam int EXP_CYC [NEXP] = '{C_PALL, C_REF0, C_REF0 + TRC, C_REF0 + 2*TRC,
                                    C_REF0 + 3*TRC, C_REF0 + 4*TRC, C_REF0 + 5*TRC,
                                    C_REF0 + 6*TRC, C_REF0 + 7*TRC, C_MRS};
  localparam logic [MODE_W-1:0] MODE = 7'h23;

  logic clk = 1'b0, rst_n = 1'b0, user_idle = 1'b0;
  logic [MODE_W-1:0] mode_code = MODE;
  logic seq_ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_bank;
  logic [ADDR_W-1:0] sd_addr;

  int checks = 0, errors = 0, cyc = 0, ntr = 0, viol = 0;
  bit finished = 0;
  logic [3:0]        tr_cmd  [32];
  int                tr_cyc  [32];
  logic [ADDR_W-1:0] tr_addr [32];
  logic              tr_bank [32];

  always #10 clk = ~clk;  // 50 MHz

  sdram_init_refresh_seq #(.ADDR_W(ADDR_W), .MODE_W(MODE_W), .WAIT_CYC(WAIT),
    .TRP_CYC(TRP), .TRC_CYC(TRC), .TMRD_CYC(TMRD), .INIT_REFS(NREF),
    .REF_INTERVAL(INTV)) dut (
    .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .user_idle(user_idle),
    .seq_ready(seq_ready), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_bank(sd_bank));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  // command trace and per-cycle rule monitor (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] c;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (c == K_NOP) begin
        if (sd_addr != '0) viol++;
      end else begin
        if (seq_ready) viol++;
        if (ntr < 32) begin
          tr_cmd[ntr] = c; tr_cyc[ntr] = cyc;
          tr_addr[ntr] = sd_addr; tr_bank[ntr] = sd_bank;
          ntr++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic to_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sd_cke == 1'b0, "R1 cke", sd_cke, 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == K_NOP, "R1 cmd",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, K_NOP);
    chk(seq_ready == 1'b0 && sd_addr == '0, "R1 ready/addr", seq_ready, 0);
    rst_n = 1'b1;

    // R2: pause length and CKE rise
    to_cyc(WAIT - 1);
    chk(sd_cke == 1'b0 && ntr == 0, "R2 cke low end of pause", sd_cke, 0);
    to_cyc(WAIT);
    chk(sd_cke == 1'b1, "R2 cke high", sd_cke, 1);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == K_NOP, "R2 nop with cke",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, K_NOP);

    // R3 R4 R5: power-up command table
    to_cyc(C_RDY + 2);
    chk(ntr == NEXP, "R4 power-up command count", ntr, NEXP);
    for (int i = 0; i < NEXP; i++) begin
      chk(tr_cmd[i] == EXP_CMD[i], (i == 0) ? "R3 cmd" : (i == NEXP-1) ? "R5 cmd" : "R4 cmd",
          tr_cmd[i], EXP_CMD[i]);
      chk(tr_cyc[i] == EXP_CYC[i], (i == 0) ? "R3 cycle" : (i == NEXP-1) ? "R5 cycle" : "R4 cycle",
          tr_cyc[i], EXP_CYC[i]);
    end
    chk(tr_addr[0][ADDR_W-1] == 1'b1, "R3 A10 high", tr_addr[0][ADDR_W-1], 1);
    chk(tr_addr[NEXP-1] == ADDR_W'(MODE) && tr_bank[NEXP-1] == 1'b0, "R5 mode address",
        tr_addr[NEXP-1], MODE);

    // R6: ready edge (checked retroactively via trace plus level now)
    chk(seq_ready == 1'b1, "R6 ready up", seq_ready, 1);

    // R7: first request pending exactly INTV after ready
    to_cyc(P1 - 1);
    chk(seq_ready == 1'b1, "R7 ready before request", seq_ready, 1);
    to_cyc(P1);
    chk(seq_ready == 1'b0, "R7 ready drops on request", seq_ready, 0);

    // R8: held off while user busy
    to_cyc(P1 + 10);
    chk(ntr == NEXP, "R8 no command while user busy", ntr, NEXP);
    chk(seq_ready == 1'b0, "R8 ready stays low", seq_ready, 0);
    user_idle = 1'b1;

    // R9: service sequence
    to_cyc(P1 + 11 + TRP + TRC - 1);
    chk(seq_ready == 1'b0, "R9 ready low during tRC", seq_ready, 0);
    to_cyc(P1 + 11 + TRP + TRC);
    chk(seq_ready == 1'b1, "R9 ready back", seq_ready, 1);
    chk(tr_cmd[NEXP] == K_PALL && tr_cyc[NEXP] == P1 + 11, "R9 precharge cycle",
        tr_cyc[NEXP], P1 + 11);
    chk(tr_addr[NEXP][ADDR_W-1] == 1'b1, "R9 precharge A10", tr_addr[NEXP][ADDR_W-1], 1);
    chk(tr_cmd[NEXP+1] == K_REF && tr_cyc[NEXP+1] == P1 + 11 + TRP, "R9 refresh cycle",
        tr_cyc[NEXP+1], P1 + 11 + TRP);

    // R7: interval is free-running despite late service
    to_cyc(P1 + INTV);
    chk(seq_ready == 1'b0, "R7 second request", seq_ready, 0);
    to_cyc(P1 + INTV + 10);
    chk(ntr == NEXP + 4, "R7 second service count", ntr, NEXP + 4);
    chk(tr_cmd[NEXP+2] == K_PALL && tr_cyc[NEXP+2] == P1 + INTV + 1,
        "R7 second precharge cycle", tr_cyc[NEXP+2], P1 + INTV + 1);

    // R10: per-cycle monitor tally
    chk(viol == 0, "R10 bus rule violations", viol, 0);

    // R1: reset in the middle of a service
    to_cyc(P1 + 2*INTV + 1);
    rst_n = 1'b0;
    #1;
    chk(sd_cke == 1'b0 && seq_ready == 1'b0, "R1 mid-run reset", sd_cke, 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == K_NOP && sd_addr == '0,
        "R1 mid-run reset cmd", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, K_NOP);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule